// File: doc/BRIEF.md
# Line Interface Activation Mode Controller

This block decides whether the ISDN S line interface may be brought up. It holds one of three modes. In quiet the line interface is held off completely. In inactive the line is watched for an incoming signal. In active the interface is in service. Inputs come from several sources:

- host power-up and power-down primitives, each a single-cycle strobe;
- an enable bit from the host control word;
- an asynchronous active-low line-signal-detect input;
- the USB configured, suspended and resume-done indications;
- two static straps, one selecting the mode after reset and one declaring remote-wake ability.

The block drives a 2-bit mode code, an enable for the line-signal detector, an enable for the oscillator clock to the line macro, and a one-cycle remote-wake request toward the USB side.

While the bus is configured and running, a detected line signal or a power-up primitive activates the interface immediately. While the bus is suspended, a detected line signal only arms a deferred activation. That activation completes when the USB side reports that resume signalling has finished. If wake-up ability is declared, the same detection also raises a remote-wake pulse. A suspend event or a power-down primitive returns an active interface to inactive. Clearing the host enable bit forces quiet from any mode.

Top module: `lnact_mode_ctrl`

## Requirements
- R1: On the asynchronous reset (rst_n low) and on the synchronous default request (dflt_rst_i high at a clock edge), the mode becomes inactive when cfg_init_i is 1 and quiet when it is 0.
- R2: In quiet (mode_o = 2'b00), det_en_o and osc_en_o are 0. Power-up primitives and line-detect falls leave the mode at quiet.
- R3: In inactive (mode_o = 2'b01), det_en_o and osc_en_o are 1. In active (mode_o = 2'b10), det_en_o is 0 and osc_en_o is 1.
- R4: In inactive with ctl_en_i = 1, cfgd_i = 1 and susp_i = 0, a power-up strobe without power-down gives active at the next clock edge.
- R5: lsd_n_i passes through a synchronizer of SYNC_STAGES flops (2 by default). A high-to-low fall observed in inactive while configured and not suspended gives active three clock edges after the input changes.
- R6: A line-detect fall in inactive while suspended leaves the mode at inactive and arms a deferred activation. A later resume_i strobe then gives active at the next edge. A power-down strobe in between cancels the deferred activation.
- R7: wake_req_o is a one-cycle pulse. It coincides with the edge at which a suspended-state line-detect fall is taken, and it is raised only when wake_cap_i = 1.
- R8: In active, a power-down strobe or a rising edge of susp_i gives inactive at the next edge.
- R9: With ctl_en_i = 0 the mode becomes quiet at the next edge from any mode. With ctl_en_i = 1 quiet becomes inactive at the next edge.
- R10: A power-up and a power-down strobe in the same cycle in inactive leave the mode at inactive.
- R11: mode_o never takes the code 2'b11.
- R12: In inactive, a power-up strobe is ignored while cfgd_i = 0 or susp_i = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| dflt_rst_i | input | 1 | Synchronous return to the initial mode (bus default request) |
| cfg_init_i | input | 1 | Static strap: 1 selects inactive after reset, 0 selects quiet |
| wake_cap_i | input | 1 | Static strap: remote-wake ability declared |
| pup_i | input | 1 | Host power-up primitive strobe |
| pdn_i | input | 1 | Host power-down primitive strobe |
| ctl_en_i | input | 1 | Host control enable bit for the line interface |
| lsd_n_i | input | 1 | Asynchronous active-low line-signal detect |
| cfgd_i | input | 1 | USB device configured |
| susp_i | input | 1 | USB bus suspended |
| resume_i | input | 1 | Strobe: resume signalling on the bus has completed |
| mode_o | output | 2 | Mode code: 00 quiet, 01 inactive, 10 active |
| det_en_o | output | 1 | Line-signal detector enable |
| osc_en_o | output | 1 | Oscillator clock enable to the line macro |
| wake_req_o | output | 1 | One-cycle remote-wake request |

## Verification
Strobes on the primitive, enable, suspend, resume and default-request inputs act at the next clock edge. A line-detect fall acts at the third edge after the input changes, and the wake pulse appears at that same edge and is gone one edge later. Each stimulus task records the expected mode and wake value together with the exact cycle at which it is due. The monitor compares outputs on falling edges only at those due cycles. It also checks the cycle just before a line-detect activation, so that an early transition is caught as well as a late one.

// File: rtl/lnact_pkg.sv
package lnact_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_QUIET = 2'b00,
    MODE_IDLE  = 2'b01,
    MODE_ACT   = 2'b10
  } lnact_mode_e;

endpackage

// File: rtl/lnact_lsd_sync.sv
module lnact_lsd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lsd_n_i,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;
  logic              sync_s;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= 1'b1;
        end else begin
          chain_q <= lsd_n_i;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '1;
        end else begin
          chain_q <= {chain_q[STAGES-2:0], lsd_n_i};
        end
      end
    end
  endgenerate

  assign sync_s = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b1;
    end else begin
      last_q <= sync_s;
    end
  end

  assign fall_o = last_q & ~sync_s;

  // R5: a synchronized fall is reported for exactly one cycle
  p_fall_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

endmodule

// File: rtl/lnact_fsm.sv
module lnact_fsm
  import lnact_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dflt_rst_i,
  input  logic        cfg_init_i,
  input  logic        wake_cap_i,
  input  logic        pup_i,
  input  logic        pdn_i,
  input  logic        ctl_en_i,
  input  logic        lsd_fall_i,
  input  logic        cfgd_i,
  input  logic        susp_i,
  input  logic        resume_i,
  output lnact_mode_e mode_o,
  output logic        wake_o
);

  lnact_mode_e mode_q, mode_d;
  logic        pend_q, pend_d;
  logic        wake_q, wake_d;
  logic        susp_q;
  logic        online_s;
  logic        susp_rise_s;

  assign online_s    = cfgd_i & ~susp_i;
  assign susp_rise_s = susp_i & ~susp_q;

  // next-state logic
  always_comb begin
    mode_d = mode_q;
    pend_d = pend_q;
    wake_d = 1'b0;
    if (dflt_rst_i) begin
      mode_d = cfg_init_i ? MODE_IDLE : MODE_QUIET;
      pend_d = 1'b0;
    end else begin
      case (mode_q)
        MODE_QUIET: begin
          pend_d = 1'b0;
          if (ctl_en_i) begin
            mode_d = MODE_IDLE;
          end
        end
        MODE_IDLE: begin
          if (!ctl_en_i) begin
            mode_d = MODE_QUIET;
            pend_d = 1'b0;
          end else if (pdn_i) begin
            pend_d = 1'b0;
          end else if (online_s && (pup_i || lsd_fall_i)) begin
            mode_d = MODE_ACT;
            pend_d = 1'b0;
          end else if (pend_q && resume_i) begin
            mode_d = MODE_ACT;
            pend_d = 1'b0;
          end else if (susp_i && lsd_fall_i) begin
            pend_d = 1'b1;
            wake_d = wake_cap_i;
          end
        end
        MODE_ACT: begin
          pend_d = 1'b0;
          if (!ctl_en_i) begin
            mode_d = MODE_QUIET;
          end else if (pdn_i || susp_rise_s) begin
            mode_d = MODE_IDLE;
          end
        end
        default: begin
          mode_d = MODE_QUIET;
          pend_d = 1'b0;
        end
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= cfg_init_i ? MODE_IDLE : MODE_QUIET;
      pend_q <= 1'b0;
      wake_q <= 1'b0;
      susp_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      pend_q <= pend_d;
      wake_q <= wake_d;
      susp_q <= susp_i;
    end
  end

  assign mode_o = mode_q;
  assign wake_o = wake_q;

  p_reset_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dflt_rst_i |=> mode_q == ($past(cfg_init_i) ? MODE_IDLE : MODE_QUIET));

  p_quiet_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_QUIET && !ctl_en_i && !dflt_rst_i) |=> mode_q == MODE_QUIET);

  p_pup_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IDLE && ctl_en_i && cfgd_i && !susp_i && pup_i && !pdn_i && !dflt_rst_i)
      |=> mode_q == MODE_ACT);

  p_wake_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |=> !wake_q);

  p_wake_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> $past(wake_cap_i) && $past(susp_i));

  p_act_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ACT && ctl_en_i && pdn_i && !dflt_rst_i) |=> mode_q == MODE_IDLE);

  p_ctl_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en_i && !dflt_rst_i) |=> mode_q == MODE_QUIET);

  p_pdn_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IDLE && ctl_en_i && pdn_i && !dflt_rst_i) |=> mode_q == MODE_IDLE);

  p_legal_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != 2'b11);

  p_pup_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IDLE && ctl_en_i && !dflt_rst_i && !lsd_fall_i && !resume_i && (!cfgd_i || susp_i))
      |=> mode_q == MODE_IDLE);

endmodule

// File: rtl/lnact_outdec.sv
module lnact_outdec
  import lnact_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  lnact_mode_e mode_i,
  output logic        det_en_o,
  output logic        osc_en_o
);

  always_comb begin
    det_en_o = 1'b0;
    osc_en_o = 1'b0;
    case (mode_i)
      MODE_IDLE: begin
        det_en_o = 1'b1;
        osc_en_o = 1'b1;
      end
      MODE_ACT: begin
        osc_en_o = 1'b1;
      end
      default: begin
        det_en_o = 1'b0;
        osc_en_o = 1'b0;
      end
    endcase
  end

  p_quiet_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_QUIET) |-> (!det_en_o && !osc_en_o));

  p_idle_detect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_IDLE) |-> (det_en_o && osc_en_o));

  p_act_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_ACT) |-> (!det_en_o && osc_en_o));

endmodule

// File: rtl/lnact_mode_ctrl.sv
module lnact_mode_ctrl
  import lnact_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dflt_rst_i,
  input  logic              cfg_init_i,
  input  logic              wake_cap_i,
  input  logic              pup_i,
  input  logic              pdn_i,
  input  logic              ctl_en_i,
  input  logic              lsd_n_i,
  input  logic              cfgd_i,
  input  logic              susp_i,
  input  logic              resume_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              det_en_o,
  output logic              osc_en_o,
  output logic              wake_req_o
);

  logic        lsd_fall_s;
  lnact_mode_e mode_s;

  lnact_lsd_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .lsd_n_i (lsd_n_i),
    .fall_o  (lsd_fall_s)
  );

  lnact_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .dflt_rst_i (dflt_rst_i),
    .cfg_init_i (cfg_init_i),
    .wake_cap_i (wake_cap_i),
    .pup_i      (pup_i),
    .pdn_i      (pdn_i),
    .ctl_en_i   (ctl_en_i),
    .lsd_fall_i (lsd_fall_s),
    .cfgd_i     (cfgd_i),
    .susp_i     (susp_i),
    .resume_i   (resume_i),
    .mode_o     (mode_s),
    .wake_o     (wake_req_o)
  );

  lnact_outdec u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode_s),
    .det_en_o (det_en_o),
    .osc_en_o (osc_en_o)
  );

  assign mode_o = mode_s;

endmodule

// File: tb/lnact_mode_ctrl_tb.sv
module lnact_mode_ctrl_tb;

  localparam logic [1:0] QT = 2'b00;
  localparam logic [1:0] IN = 2'b01;
  localparam logic [1:0] AC = 2'b10;

  typedef struct {
    int         due;
    logic [1:0] mode;
    logic       wake;
    string      req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n, dflt_rst, cfg_init, wake_cap, pup, pdn, ctl_en;
  logic lsd_n, cfgd, susp, resume;
  logic [1:0] mode;
  logic det_en, osc_en, wake_req;

  int   cyc   = 0;
  int   total = 0;
  int   bad   = 0;
  bit   done  = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lnact_mode_ctrl u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .dflt_rst_i (dflt_rst),
    .cfg_init_i (cfg_init),
    .wake_cap_i (wake_cap),
    .pup_i      (pup),
    .pdn_i      (pdn),
    .ctl_en_i   (ctl_en),
    .lsd_n_i    (lsd_n),
    .cfgd_i     (cfgd),
    .susp_i     (susp),
    .resume_i   (resume),
    .mode_o     (mode),
    .det_en_o   (det_en),
    .osc_en_o   (osc_en),
    .wake_req_o (wake_req)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_at(input int dly, input logic [1:0] m, input logic w, input string r);
    exp_t e;
    e.due  = cyc + dly;
    e.mode = m;
    e.wake = w;
    e.req  = r;
    q.push_back(e);
  endtask

  // monitor: compares each expectation in its due cycle
  // (detector enabled in inactive only, clock enabled out of quiet, R2/R3)
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      logic exp_det, exp_osc;
      e = q.pop_front();
      exp_det = (e.mode == IN);
      exp_osc = (e.mode != QT);
      total++;
      if (e.due != cyc || mode !== e.mode || wake_req !== e.wake ||
          det_en !== exp_det || osc_en !== exp_osc) begin
        bad++;
        $display("FAIL %s cyc=%0d: mode=%b wake=%b det=%b osc=%b, expected mode=%b wake=%b det=%b osc=%b",
                 e.req, cyc, mode, wake_req, det_en, osc_en, e.mode, e.wake, exp_det, exp_osc);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired at cyc=%0d, expected completion", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dflt_rst = 1'b0; cfg_init = 1'b0; wake_cap = 1'b0;
    pup = 1'b0; pdn = 1'b0; ctl_en = 1'b0; lsd_n = 1'b1;
    cfgd = 1'b0; susp = 1'b0; resume = 1'b0;
    tick(2);
    expect_at(1, QT, 1'b0, "R1");          // reset with strap 0 -> quiet
    tick(1);
    rst_n = 1'b1;
    tick(2);

    // R2: quiet ignores power-up and line detect
    cfgd = 1'b1; pup = 1'b1;
    expect_at(1, QT, 1'b0, "R2");
    tick(1); pup = 1'b0;
    lsd_n = 1'b0;
    expect_at(3, QT, 1'b0, "R2");
    tick(4); lsd_n = 1'b1; tick(4);

    // R9: enable bit moves quiet to inactive (R3 outputs checked too)
    ctl_en = 1'b1;
    expect_at(1, IN, 1'b0, "R9");
    tick(2);

    // R12: power-up ignored while unconfigured
    cfgd = 1'b0; pup = 1'b1;
    expect_at(1, IN, 1'b0, "R12");
    tick(1); pup = 1'b0; cfgd = 1'b1; tick(1);

    // R10: power-down wins over simultaneous power-up
    pup = 1'b1; pdn = 1'b1;
    expect_at(1, IN, 1'b0, "R10");
    tick(1); pup = 1'b0; pdn = 1'b0; tick(1);

    // R4: power-up activates
    pup = 1'b1;
    expect_at(1, AC, 1'b0, "R4");
    tick(1); pup = 1'b0; tick(1);

    // R8: power-down deactivates
    pdn = 1'b1;
    expect_at(1, IN, 1'b0, "R8");
    tick(1); pdn = 1'b0; tick(1);

    // R5: line-detect fall activates after three edges, not before
    lsd_n = 1'b0;
    expect_at(2, IN, 1'b0, "R5");
    expect_at(3, AC, 1'b0, "R5");
    tick(4); lsd_n = 1'b1; tick(3);

    // R8: suspend edge deactivates
    susp = 1'b1;
    expect_at(1, IN, 1'b0, "R8");
    tick(2);

    // R6/R7: suspended detect defers, no wake without capability
    lsd_n = 1'b0;
    expect_at(3, IN, 1'b0, "R7");
    expect_at(5, IN, 1'b0, "R6");
    tick(6); lsd_n = 1'b1; tick(3);
    resume = 1'b1; susp = 1'b0;
    expect_at(1, AC, 1'b0, "R6");
    tick(1); resume = 1'b0; tick(1);

    susp = 1'b1;
    expect_at(1, IN, 1'b0, "R8");
    tick(2);

    // R7: wake pulse with capability, one cycle wide
    wake_cap = 1'b1; lsd_n = 1'b0;
    expect_at(3, IN, 1'b1, "R7");
    expect_at(4, IN, 1'b0, "R7");
    tick(5); lsd_n = 1'b1;
    pup = 1'b1;                           // R12: ignored while suspended
    expect_at(1, IN, 1'b0, "R12");
    tick(1); pup = 1'b0; tick(2);
    susp = 1'b0; resume = 1'b1;
    expect_at(1, AC, 1'b0, "R6");
    tick(1); resume = 1'b0; tick(1);

    // R9: clearing the enable forces quiet from active
    ctl_en = 1'b0;
    expect_at(1, QT, 1'b0, "R9");
    tick(2);

    // R6: power-down cancels a deferred activation
    ctl_en = 1'b1;
    expect_at(1, IN, 1'b0, "R9");
    tick(1); susp = 1'b1; tick(1);
    lsd_n = 1'b0;
    expect_at(3, IN, 1'b1, "R7");
    tick(4); lsd_n = 1'b1;
    pdn = 1'b1; tick(1); pdn = 1'b0;
    susp = 1'b0; resume = 1'b1;
    expect_at(1, IN, 1'b0, "R6");
    tick(1); resume = 1'b0; tick(1);

    // R1: default request with both strap values
    cfg_init = 1'b1; pup = 1'b1;
    expect_at(1, AC, 1'b0, "R4");
    tick(1); pup = 1'b0; tick(1);
    dflt_rst = 1'b1;
    expect_at(1, IN, 1'b0, "R1");
    tick(1); dflt_rst = 1'b0; tick(1);
    cfg_init = 1'b0; dflt_rst = 1'b1;
    expect_at(1, QT, 1'b0, "R1");
    tick(1); dflt_rst = 1'b0; tick(1);

    // R1: asynchronous reset with strap 1
    cfg_init = 1'b1; rst_n = 1'b0;
    expect_at(1, IN, 1'b0, "R1");
    tick(1); rst_n = 1'b1; tick(3);

    if (q.size() != 0) begin
      bad++;
      $display("FAIL pending expectations=%0d, expected 0", q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule